// File: doc/BRIEF.md
# LIN Slave Header and Frame Monitor

This block is the protocol engine of a LIN slave node. It runs on a byte stream that a receiver has already deserialised. Besides each byte, the receiver reports when it detected a break and when a byte had a bad stop bit. The engine recognises a header: a break, then the synchronisation byte, then the protected identifier. After a good header it counts the response bytes, which are the configured number of data bytes followed by one checksum byte. When the full response has arrived in time, it signals a completed frame.

Frame timing is supervised with a counter of bit-time ticks that restarts at every break. The header may last at most 1.4 times its nominal 34 bit times, rounded up to 48 ticks. The response may add at most 1.4 times its nominal 10·(N+1) bit times, which is 14·(N+1) ticks. A break that arrives where response bytes are expected is taken as the start of a new header, not as an error. A slave therefore recovers cleanly when a master sends back-to-back headers.

Top module: `lin_slave_monitor`

## Requirements
- R1: A break indication moves the engine to the sync state on the next clock edge from any state and clears all four error flags. A framing error reported in the same cycle as the break does not set the framing error flag.
- R2: In the sync state, a received byte equal to 0x55 moves the engine to the identifier state. Any other byte sets the sync error flag and returns the engine to idle.
- R3: In the identifier state the engine takes one byte as the protected identifier. Bit 6 must equal id0^id1^id2^id4. Bit 7 must equal the inverse of id1^id3^id4^id5. On a match the engine enters the response state and `pid_o` shows bits 5:0 of the byte. On a mismatch the parity error flag is set and the engine returns to idle.
- R4: `state_o` encodes idle as 0000, sync as 0010, identifier as 0011 and data reception as 0101. No other value ever appears.
- R5: In the response state, after N+1 bytes (N = `data_len_i`, valid range 1 to 8), `frame_done_o` pulses high for exactly one cycle and the engine returns to idle. This happens only if no timeout occurred in the frame.
- R6: A framing error indication in the sync, identifier or response state sets the framing error flag and returns the engine to idle.
- R7: While in the sync or identifier state, a count of more than 48 bit ticks since the last break sets the timeout flag. A count of exactly 48 does not.
- R8: While in the response state, a count of more than 48 + 14·(N+1) bit ticks since the last break sets the timeout flag. If the timeout is set, `frame_done_o` stays low for that frame.
- R9: With `idle_on_to_i` high, a timeout returns the engine to idle. With it low, the engine stays in its state, keeps accepting bytes and returns to idle after the last byte, without a frame-done pulse.
- R10: In idle, received bytes and framing error indications have no effect. The state stays idle and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| rx_valid_i | input | 1 | A received byte is present on `rx_byte_i` |
| rx_byte_i | input | 8 | Received byte |
| brk_det_i | input | 1 | Break detected by the receiver |
| rx_ferr_i | input | 1 | Receiver framing error (bad stop bit) |
| data_len_i | input | LEN_W (4) | Data bytes per response, 1 to 8 |
| idle_on_to_i | input | 1 | Return to idle on timeout |
| state_o | output | 4 | Engine state code |
| pid_o | output | 6 | Identifier of the last accepted header |
| sync_err_o | output | 1 | Sync byte was not 0x55 (sticky until break) |
| par_err_o | output | 1 | Identifier parity mismatch (sticky until break) |
| frm_err_o | output | 1 | Framing error in a frame (sticky until break) |
| to_err_o | output | 1 | Header or frame time exceeded (sticky until break) |
| frame_done_o | output | 1 | One-cycle pulse on a completed response |

## Verification
Every result of a byte, break or framing indication is registered on the edge that samples the input. It is therefore visible one cycle after the stimulus. The bench drives on falling edges and reads on the following falling edge. A timeout needs one more edge, because the counter first passes its limit and the flag is then registered on the next edge. For that reason the bench waits two cycles after the deciding tick before it checks. The scoreboard monitor samples every falling edge, so it catches the single-cycle frame-done pulse and every rising error flag in the cycle it appears.

// File: rtl/lin_mon_pkg.sv
package lin_mon_pkg;

   typedef enum logic [3:0] {
      ST_IDLE  = 4'b0000,
      ST_SYNC  = 4'b0010,
      ST_IDENT = 4'b0011,
      ST_RESP  = 4'b0101
   } lin_st_e;

   localparam logic [7:0] SYNC_VAL   = 8'h55;
   localparam int         HDR_NOM    = 34;
   localparam int         SCALE_NUM  = 14;
   localparam int         SCALE_DEN  = 10;

   // maximum duration = nominal * 1.4, rounded up to whole bit ticks
   function automatic int max_ticks(input int nominal);
      return (nominal * SCALE_NUM + SCALE_DEN - 1) / SCALE_DEN;
   endfunction

   function automatic int rsp_nominal(input int nbytes);
      return 10 * (nbytes + 1);
   endfunction

endpackage

// File: rtl/lin_pid_check.sv
module lin_pid_check #(
   parameter bit PARITY_EN = 1'b1
) (
   input  logic [7:0] pid_byte_i,
   output logic       pid_ok_o
);
   generate
      if (PARITY_EN) begin : g_parity
         logic p0_exp, p1_exp;
         assign p0_exp   = pid_byte_i[0] ^ pid_byte_i[1] ^ pid_byte_i[2] ^ pid_byte_i[4];
         assign p1_exp   = ~(pid_byte_i[1] ^ pid_byte_i[3] ^ pid_byte_i[4] ^ pid_byte_i[5]);
         assign pid_ok_o = (pid_byte_i[6] == p0_exp) && (pid_byte_i[7] == p1_exp);
      end else begin : g_no_parity
         logic unused_bits;
         assign unused_bits = ^pid_byte_i;
         assign pid_ok_o    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/lin_frame_timer.sv
module lin_frame_timer
   import lin_mon_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int LEN_W   = 4,
   parameter int MAX_LEN = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic             tick_i,
   input  logic             active_i,
   input  logic             in_resp_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             hit_o
);
   localparam int               HDR_LIM   = max_ticks(HDR_NOM);
   localparam logic [CNT_W-1:0] HDR_LIM_W = CNT_W'(HDR_LIM);
   localparam logic [CNT_W-1:0] CNT_SAT   = {CNT_W{1'b1}};

   logic [CNT_W-1:0] frm_lim_tab [0:MAX_LEN];
   logic [CNT_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_idx;
   logic [CNT_W-1:0] frm_lim;

   for (genvar g = 0; g <= MAX_LEN; g++) begin : g_lim
      assign frm_lim_tab[g] = CNT_W'(HDR_LIM + max_ticks(rsp_nominal(g)));
   end

   assign len_idx = (len_i > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_i;
   assign frm_lim = frm_lim_tab[len_idx];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (active_i && tick_i && cnt_q != CNT_SAT) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hit_o = active_i && (in_resp_i ? (cnt_q > frm_lim) : (cnt_q > HDR_LIM_W));
endmodule

// File: rtl/lin_slave_monitor.sv
module lin_slave_monitor
   import lin_mon_pkg::*;
#(
   parameter int LEN_W     = 4,
   parameter int MAX_LEN   = 8,
   parameter int CNT_W     = 8,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bit_tick_i,
   input  logic             rx_valid_i,
   input  logic [7:0]       rx_byte_i,
   input  logic             brk_det_i,
   input  logic             rx_ferr_i,
   input  logic [LEN_W-1:0] data_len_i,
   input  logic             idle_on_to_i,
   output logic [3:0]       state_o,
   output logic [5:0]       pid_o,
   output logic             sync_err_o,
   output logic             par_err_o,
   output logic             frm_err_o,
   output logic             to_err_o,
   output logic             frame_done_o
);
   localparam int WORST_TICKS = max_ticks(HDR_NOM) + max_ticks(rsp_nominal(MAX_LEN));

   generate
      if (MAX_LEN < 1 || MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
         $error("MAX_LEN must be at least 1 and fit in LEN_W bits");
      end
      if (WORST_TICKS >= (1 << CNT_W) - 1) begin : g_bad_cnt
         $error("CNT_W too narrow for the longest frame limit");
      end
   endgenerate

   lin_st_e          st_q;
   logic [LEN_W-1:0] bcnt_q;
   logic             pid_ok;
   logic             to_hit;

   lin_pid_check #(.PARITY_EN(PARITY_EN)) u_pid (
      .pid_byte_i (rx_byte_i),
      .pid_ok_o   (pid_ok)
   );

   lin_frame_timer #(.CNT_W(CNT_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (brk_det_i),
      .tick_i    (bit_tick_i),
      .active_i  (st_q != ST_IDLE),
      .in_resp_i (st_q == ST_RESP),
      .len_i     (data_len_i),
      .hit_o     (to_hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q         <= ST_IDLE;
         bcnt_q       <= '0;
         pid_o        <= '0;
         sync_err_o   <= 1'b0;
         par_err_o    <= 1'b0;
         frm_err_o    <= 1'b0;
         to_err_o     <= 1'b0;
         frame_done_o <= 1'b0;
      end else begin
         frame_done_o <= 1'b0;
         if (brk_det_i) begin
            // new header always wins, even over a pending response
            st_q       <= ST_SYNC;
            bcnt_q     <= '0;
            sync_err_o <= 1'b0;
            par_err_o  <= 1'b0;
            frm_err_o  <= 1'b0;
            to_err_o   <= 1'b0;
         end else begin
            if (to_hit) begin
               to_err_o <= 1'b1;
            end
            if (st_q != ST_IDLE && rx_ferr_i) begin
               frm_err_o <= 1'b1;
               st_q      <= ST_IDLE;
            end else if (to_hit && idle_on_to_i) begin
               st_q <= ST_IDLE;
            end else if (rx_valid_i) begin
               unique case (st_q)
                  ST_SYNC: begin
                     if (rx_byte_i == SYNC_VAL) begin
                        st_q <= ST_IDENT;
                     end else begin
                        sync_err_o <= 1'b1;
                        st_q       <= ST_IDLE;
                     end
                  end
                  ST_IDENT: begin
                     if (pid_ok) begin
                        pid_o  <= rx_byte_i[5:0];
                        bcnt_q <= '0;
                        st_q   <= ST_RESP;
                     end else begin
                        par_err_o <= 1'b1;
                        st_q      <= ST_IDLE;
                     end
                  end
                  ST_RESP: begin
                     if (bcnt_q == data_len_i) begin
                        st_q         <= ST_IDLE;
                        frame_done_o <= !to_err_o && !to_hit;
                     end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign state_o = st_q;
endmodule

// File: rtl/lin_slave_monitor_chk.sv
module lin_slave_monitor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       brk,
   input logic       ferr,
   input logic       rx_valid,
   input logic [7:0] rx_byte,
   input logic       idle_on_to,
   input logic [3:0] state,
   input logic       sync_err,
   input logic       frm_err,
   input logic       to_err,
   input logic       frame_done,
   input logic       to_hit
);
   a_r1_break_enters_sync: assert property (@(posedge clk) disable iff (!rst_n)
      brk |=> (state == 4'b0010 && !frm_err && !to_err));

   a_r2_bad_sync_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk && !ferr && !(to_hit && idle_on_to) && state == 4'b0010 && rx_valid
       && rx_byte != 8'h55) |=> (sync_err && state == 4'b0000));

   a_r4_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 4'b0000 || state == 4'b0010 || state == 4'b0011 || state == 4'b0101));

   a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   a_r5_done_clean_idle: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (state == 4'b0000 && !to_err));

   a_r6_ferr_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk && ferr && state != 4'b0000) |=> (frm_err && state == 4'b0000));

   a_r9_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk && to_hit && idle_on_to) |=> (to_err && state == 4'b0000));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk && state == 4'b0000) |=> (state == 4'b0000 && !frame_done));
endmodule

bind lin_slave_monitor lin_slave_monitor_chk u_chk (
   .clk        (clk_i),
   .rst_n      (rst_ni),
   .brk        (brk_det_i),
   .ferr       (rx_ferr_i),
   .rx_valid   (rx_valid_i),
   .rx_byte    (rx_byte_i),
   .idle_on_to (idle_on_to_i),
   .state      (state_o),
   .sync_err   (sync_err_o),
   .frm_err    (frm_err_o),
   .to_err     (to_err_o),
   .frame_done (frame_done_o),
   .to_hit     (to_hit)
);

// File: tb/lin_slave_monitor_bench.sv
module lin_slave_monitor_bench;
   localparam int EV_DONE = 0, EV_SYNC = 1, EV_PAR = 2, EV_FRM = 3, EV_TO = 4;

   typedef struct {
      int         kind;
      logic [5:0] pid;
   } ev_t;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       tick = 1'b0, rx_valid = 1'b0, brk = 1'b0, ferr = 1'b0, iot = 1'b1;
   logic [7:0] rx_byte = 8'h00;
   logic [3:0] dlen = 4'd2;
   logic [3:0] state;
   logic [5:0] pid;
   logic       sync_err, par_err, frm_err, to_err, done;

   int  checks = 0, errors = 0;
   bit  finished = 1'b0;
   ev_t exp_q[$];

   always #5 clk = ~clk;

   lin_slave_monitor u_lin_slave_monitor (
      .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .rx_valid_i(rx_valid),
      .rx_byte_i(rx_byte), .brk_det_i(brk), .rx_ferr_i(ferr), .data_len_i(dlen),
      .idle_on_to_i(iot), .state_o(state), .pid_o(pid), .sync_err_o(sync_err),
      .par_err_o(par_err), .frm_err_o(frm_err), .to_err_o(to_err), .frame_done_o(done)
   );

   function automatic logic [7:0] prot(input logic [5:0] id);
      logic p0, p1;
      p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
      p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return {p1, p0, id};
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic expect_ev(input int kind, input logic [5:0] p);
      ev_t e;
      e.kind = kind;
      e.pid  = p;
      exp_q.push_back(e);
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic send_brk(input logic with_ferr);
      @(negedge clk); brk = 1'b1; ferr = with_ferr;
      @(negedge clk); brk = 1'b0; ferr = 1'b0;
   endtask

   task automatic send_ferr();
      @(negedge clk); ferr = 1'b1;
      @(negedge clk); ferr = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic header(input logic [5:0] id);
      send_brk(1'b0);
      send_byte(8'h55);
      send_byte(prot(id));
   endtask

   // scoreboard monitor: every done pulse and rising error flag is an event
   logic p_sync = 1'b0, p_par = 1'b0, p_frm = 1'b0, p_to = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (done)              pop_cmp(EV_DONE, "R5 done");
         if (sync_err && !p_sync) pop_cmp(EV_SYNC, "R2 sync_err");
         if (par_err && !p_par)   pop_cmp(EV_PAR, "R3 par_err");
         if (frm_err && !p_frm)   pop_cmp(EV_FRM, "R6 frm_err");
         if (to_err && !p_to)     pop_cmp(EV_TO, "R7/R8 to_err");
         p_sync = sync_err; p_par = par_err; p_frm = frm_err; p_to = to_err;
      end
   end

   task automatic pop_cmp(input int kind, input string req);
      ev_t e;
      checks++;
      if (exp_q.size() == 0) begin
         errors++;
         $display("FAIL %s unexpected event actual=%0d expected=none", req, kind);
      end else begin
         e = exp_q.pop_front();
         if (e.kind != kind) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, kind, e.kind);
         end else if (kind == EV_DONE && pid != e.pid) begin
            errors++;
            $display("FAIL R3 pid actual=%0h expected=%0h", pid, e.pid);
         end
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R4 reset state", state, 0);
      check("R1 reset flags", {sync_err, par_err, frm_err, to_err, done}, 0);

      // good frame, two data bytes
      dlen = 4'd2;
      send_brk(1'b0);
      check("R1 break to sync", state, 4'b0010);
      send_byte(8'h55);
      check("R2 sync accepted", state, 4'b0011);
      send_byte(prot(6'h01));
      check("R4 data reception code", state, 4'b0101);
      check("R3 pid captured", pid, 6'h01);
      expect_ev(EV_DONE, 6'h01);
      send_byte(8'hA0); send_byte(8'hA1);
      check("R5 still receiving", state, 4'b0101);
      send_byte(8'h5E);
      @(negedge clk);
      check("R5 back to idle", state, 0);

      // bad sync byte
      expect_ev(EV_SYNC, 6'h00);
      send_brk(1'b0);
      send_byte(8'h54);
      check("R2 bad sync idle", state, 0);

      // parity mismatch (bit 7 flipped)
      expect_ev(EV_PAR, 6'h00);
      send_brk(1'b0);
      send_byte(8'h55);
      send_byte(prot(6'h2A) ^ 8'h80);
      check("R3 bad parity idle", state, 0);

      // new header in place of the response, break coincides with a framing error
      header(6'h3C);
      send_byte(8'h11);
      send_brk(1'b1);
      check("R1 break in response to sync", state, 4'b0010);
      check("R1 no framing error on break", frm_err, 0);
      dlen = 4'd1;
      expect_ev(EV_DONE, 6'h15);
      send_byte(8'h55);
      send_byte(prot(6'h15));
      send_byte(8'h22); send_byte(8'h33);
      @(negedge clk);
      check("R5 frame after restart", state, 0);

      // framing error in identifier state
      expect_ev(EV_FRM, 6'h00);
      send_brk(1'b0);
      send_byte(8'h55);
      send_ferr();
      check("R6 ferr to idle", state, 0);

      // inputs ignored while idle
      send_byte(8'h55);
      send_ferr();
      @(negedge clk);
      check("R10 idle stays idle", state, 0);
      check("R10 frm_err unchanged", frm_err, 1);
      check("R10 sync_err unchanged", sync_err, 0);

      // header timeout boundary: 48 ticks fine, 49th trips
      send_brk(1'b0);
      ticks(48);
      @(negedge clk);
      check("R7 48 ticks no timeout", to_err, 0);
      check("R7 still in sync", state, 4'b0010);
      expect_ev(EV_TO, 6'h00);
      ticks(1);
      repeat (2) @(negedge clk);
      check("R9 timeout to idle", state, 0);

      // response timeout, one data byte: limit 48+28=76, stay in state
      iot = 1'b0;
      dlen = 4'd1;
      header(6'h07);
      ticks(76);
      @(negedge clk);
      check("R8 76 ticks no timeout", to_err, 0);
      check("R8 still receiving", state, 4'b0101);
      expect_ev(EV_TO, 6'h00);
      ticks(1);
      repeat (2) @(negedge clk);
      check("R9 no idle when disabled", state, 4'b0101);
      send_byte(8'h01); send_byte(8'h02);
      @(negedge clk);
      check("R9 idle after last byte, no done", state, 0);
      iot = 1'b1;

      // longest response: eight data bytes
      dlen = 4'd8;
      expect_ev(EV_DONE, 6'h3F);
      header(6'h3F);
      for (int i = 0; i < 9; i++) send_byte(8'(i + 8'h40));
      repeat (2) @(negedge clk);
      check("R5 eight byte frame idle", state, 0);

      check("R5 all expected events seen", exp_q.size(), 0);
      finish_run();
   end
endmodule